// File: doc/BRIEF.md
# Parallel Port with Edge Interrupt

This block is an 8-bit general-purpose parallel port on a small synchronous CPU bus. Each pin can be an input or an output, chosen bit by bit through a direction register. Output pins carry the value held in an output latch. A read of the port returns the live pin level for input bits and the latch value for output bits. Only two bus addresses are decoded. Address 0 is shared between the direction register and the port data, and a bit in the control register at address 1 chooses which of the two it reaches.

A separate control-line input is brought into the clock domain through a synchronizer. A transition of the chosen polarity on that line sets an interrupt flag. When enabled, the flag drives an active-low interrupt request. Software services the request by reading the port data, and that read clears the flag as a side effect. A typical driver does four things. It selects the direction register and writes zero to make every pin an input. It then writes 0x07 to the control register to enable the request, pick the rising edge and select the port data. From then on, each interrupt is handled with a single data read.

Top module: `pport_edge_irq`

## Requirements
- R1: After reset the direction register, output latch and control register are all zero. `irq_n` is 1, `pin_oe` is 0 and `pin_out` is 0.
- R2: While control bit 2 is 0, bus address 0 reaches the direction register: writes load it and reads return it. Such writes leave the output latch unchanged.
- R3: While control bit 2 is 1, bus address 0 reaches the output latch. Such writes leave the direction register unchanged.
- R4: A direction bit of 1 makes the matching pin an output (`pin_oe` bit high) and a 0 makes it an input. `pin_out` always carries the output latch.
- R5: A read of the port data returns `pin_in` for input bits and the latch for output bits.
- R6: With control bit 1 set to 1, a low-to-high transition of `ctl_in` sets the flag (control read bit 7), and a high-to-low transition does not.
- R7: With control bit 1 set to 0, a high-to-low transition of `ctl_in` sets the flag, and a low-to-high transition does not.
- R8: `irq_n` is low exactly when the flag and control bit 0 (enable) are both 1. The flag is set by an active edge even while the enable bit is 0.
- R9: A read of address 0 while control bit 2 is 1 clears the flag. Reads of the control register or of the direction register leave it set.
- R10: An active edge that is detected in the same clock as a clearing read leaves the flag set.
- R11: Control bits 6:3 read as 0, and writes to control bit 7 have no effect on the flag.
- R12: `ctl_in` passes through two synchronizer stages. The flag becomes visible after the third rising clock edge following the transition, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register address: 0 port/direction, 1 control |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| pin_in | input | 8 | Pin levels sampled from the pads |
| pin_out | output | 8 | Output latch driven toward the pads |
| pin_oe | output | 8 | Per-pin output enable (1 = output) |
| ctl_in | input | 1 | Asynchronous control line that raises the interrupt |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets the clear-versus-set race. It lands a clearing data read in the very clock where a synchronized edge is detected, so a design that gives the read priority would lose that interrupt. It also counts synchronizer latency edge by edge, which catches a chain that is one stage short or long. It reads through the shared address with the selector in both states, which exposes a swapped decode that would write the latch when the direction was meant. Edges of the wrong polarity, writes to the flag bit and accesses to the non-data registers are all shown to leave the flag unchanged. A design that cleared the flag on any read, or let software set it, would fail those checks.

// File: rtl/pport_pkg.sv
`timescale 1ns/1ps
package pport_pkg;
   localparam int BUS_W         = 8;
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_EDGE_BIT = 1;
   localparam int CTRL_SEL_BIT  = 2;
   localparam int CTRL_FLAG_BIT = 7;
   localparam logic ADDR_PORT   = 1'b0;
   localparam logic ADDR_CTRL   = 1'b1;

   typedef struct packed {
      logic sel_data;
      logic rise_edge;
      logic irq_en;
   } ctrl_t;
endpackage

// File: rtl/pport_sync_edge.sv
`timescale 1ns/1ps
module pport_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   input  logic rise_sel,
   output logic edge_hit
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              synced;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("pport_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[LAST-1:0], async_in};
         prev_q  <= chain_q[LAST];
      end
   end

   assign synced = chain_q[LAST];

   always_comb begin
      if (rise_sel) edge_hit = synced & ~prev_q;
      else          edge_hit = ~synced & prev_q;
   end
endmodule

// File: rtl/pport_pin_slice.sv
`timescale 1ns/1ps
module pport_pin_slice (
   input  logic dir_bit,
   input  logic latch_bit,
   input  logic pad_bit,
   output logic oe_bit,
   output logic drive_bit,
   output logic read_bit
);
   assign oe_bit    = dir_bit;
   assign drive_bit = latch_bit;
   assign read_bit  = dir_bit ? latch_bit : pad_bit;
endmodule

// File: rtl/pport_edge_irq.sv
`timescale 1ns/1ps
module pport_edge_irq
   import pport_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_addr,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic [BUS_W-1:0] pin_in,
   output logic [BUS_W-1:0] pin_out,
   output logic [BUS_W-1:0] pin_oe,
   input  logic             ctl_in,
   output logic             irq_n
);
   localparam int PAD_W = BUS_W - DATA_W;

   generate
      if (DATA_W < 1 || DATA_W > BUS_W) begin : g_bad_width
         $error("pport_edge_irq: DATA_W must be 1..8");
      end
   endgenerate

   logic [DATA_W-1:0] ddr_q;
   logic [DATA_W-1:0] lat_q;
   logic [DATA_W-1:0] oe_w, drv_w, rd_w;
   ctrl_t             ctrl_q;
   logic              flag_q;
   logic              edge_hit;
   logic              sel_q, en_q;
   logic              wr_port, wr_ctrl, clear_rd;

   assign sel_q = ctrl_q.sel_data;
   assign en_q  = ctrl_q.irq_en;

   assign wr_port  = bus_wr && (bus_addr == ADDR_PORT);
   assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
   assign clear_rd = bus_rd && (bus_addr == ADDR_PORT) && sel_q;

   // Register file behind the shared port address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ddr_q  <= '0;
         lat_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_port) begin
            if (sel_q) lat_q <= bus_wdata[DATA_W-1:0];
            else       ddr_q <= bus_wdata[DATA_W-1:0];
         end
         if (wr_ctrl) begin
            ctrl_q.irq_en    <= bus_wdata[CTRL_EN_BIT];
            ctrl_q.rise_edge <= bus_wdata[CTRL_EDGE_BIT];
            ctrl_q.sel_data  <= bus_wdata[CTRL_SEL_BIT];
         end
      end
   end

   pport_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ctl_in),
      .rise_sel (ctrl_q.rise_edge),
      .edge_hit (edge_hit)
   );

   // Edge beats clear so a request landing during service is kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (edge_hit) flag_q <= 1'b1;
      else if (clear_rd) flag_q <= 1'b0;
   end

   assign irq_n = ~(flag_q & en_q);

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_pin
         pport_pin_slice u_slice (
            .dir_bit   (ddr_q[i]),
            .latch_bit (lat_q[i]),
            .pad_bit   (pin_in[i]),
            .oe_bit    (oe_w[i]),
            .drive_bit (drv_w[i]),
            .read_bit  (rd_w[i])
         );
      end
      if (PAD_W > 0) begin : g_pad
         assign pin_oe  = {{PAD_W{1'b0}}, oe_w};
         assign pin_out = {{PAD_W{1'b0}}, drv_w};
      end else begin : g_full
         assign pin_oe  = oe_w;
         assign pin_out = drv_w;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_CTRL) begin
         bus_rdata[CTRL_EN_BIT]   = ctrl_q.irq_en;
         bus_rdata[CTRL_EDGE_BIT] = ctrl_q.rise_edge;
         bus_rdata[CTRL_SEL_BIT]  = ctrl_q.sel_data;
         bus_rdata[CTRL_FLAG_BIT] = flag_q;
      end else if (sel_q) begin
         bus_rdata[DATA_W-1:0] = rd_w;
      end else begin
         bus_rdata[DATA_W-1:0] = ddr_q;
      end
   end
endmodule

// File: rtl/pport_edge_irq_chk.sv
`timescale 1ns/1ps
module pport_edge_irq_chk #(
   parameter int DATA_W = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_addr,
   input logic       bus_rd,
   input logic       bus_wr,
   input logic [7:0] bus_wdata,
   input logic [7:0] pin_out,
   input logic [7:0] pin_oe,
   input logic       irq_n,
   input logic       flag_q,
   input logic       sel_q,
   input logic       en_q,
   input logic       edge_hit
);
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (irq_n && pin_oe == 8'h00 && pin_out == 8'h00)
            else $error("R1 outputs not idle in reset");
      end
   end

   a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr && !sel_q) |=>
         (pin_oe[DATA_W-1:0] == $past(bus_wdata[DATA_W-1:0])) && $stable(pin_out));

   a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr && sel_q) |=>
         (pin_out[DATA_W-1:0] == $past(bus_wdata[DATA_W-1:0])) && $stable(pin_oe));

   a_r8_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q) |-> irq_n);

   a_r8_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n) |-> flag_q);

   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_addr && sel_q && !edge_hit) |=> !flag_q);

   a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> flag_q);

   a_r11_flag_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_hit && !(bus_rd && !bus_addr && sel_q)) |=> $stable(flag_q));
endmodule

bind pport_edge_irq pport_edge_irq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq_n     (irq_n),
   .flag_q    (flag_q),
   .sel_q     (sel_q),
   .en_q      (en_q),
   .edge_hit  (edge_hit)
);

// File: tb/pport_edge_irq_bench.sv
`timescale 1ns/1ps
module pport_edge_irq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_addr = 1'b0;
   logic       bus_rd = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_out;
   logic [7:0] pin_oe;
   logic       ctl_in = 1'b0;
   logic       irq_n;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;
   logic [7:0] rv;

   always #5 clk = ~clk;

   pport_edge_irq u_pport_edge_irq (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .ctl_in(ctl_in), .irq_n(irq_n)
   );

   // {direction, latch, pins, expected port read}
   localparam logic [31:0] VEC [6] = '{
      32'h00_FF_A5_A5,
      32'hFF_3C_A5_3C,
      32'hF0_5A_0F_5F,
      32'h0F_5A_C3_CA,
      32'hAA_FF_00_AA,
      32'h55_00_FF_AA
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // All bus tasks start and end just after a falling edge
   task automatic wr(input logic a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      check("R1 irq_n", {7'd0, irq_n}, 8'h01);
      check("R1 pin_oe", pin_oe, 8'h00);
      check("R1 pin_out", pin_out, 8'h00);
      rd(1'b1, rv); check("R1 ctrl", rv, 8'h00);
      rd(1'b0, rv); check("R1 dir", rv, 8'h00);

      // Table walk: R2 R3 R4 R5
      foreach (VEC[i]) begin
         wr(1'b1, 8'h00);
         wr(1'b0, VEC[i][31:24]);
         wr(1'b1, 8'h04);
         wr(1'b0, VEC[i][23:16]);
         pin_in = VEC[i][15:8];
         rd(1'b0, rv); check("R5 port read", rv, VEC[i][7:0]);
         check("R4 pin_oe", pin_oe, VEC[i][31:24]);
         check("R4 pin_out", pin_out, VEC[i][23:16]);
         wr(1'b1, 8'h00);
         rd(1'b0, rv); check("R3 dir kept", rv, VEC[i][31:24]);
      end

      // R2 direction write leaves latch alone
      wr(1'b1, 8'h04); wr(1'b0, 8'h99);
      wr(1'b1, 8'h00); wr(1'b0, 8'hF0);
      check("R2 latch kept", pin_out, 8'h99);
      check("R2 dir loaded", pin_oe, 8'hF0);

      // R12 and R6: rising mode, synchronizer latency
      wr(1'b1, 8'h07);
      ctl_in = 1'b1;
      idle(2);
      rd(1'b1, rv); check("R12 not after 2 edges", rv, 8'h07);
      rd(1'b1, rv); check("R12 set after 3 edges", rv, 8'h87);
      check("R8 irq asserted", {7'd0, irq_n}, 8'h00);

      // R9 non-clearing reads, then clearing read
      rd(1'b1, rv); check("R9 ctrl read keeps", rv, 8'h87);
      wr(1'b1, 8'h03);
      rd(1'b0, rv);
      rd(1'b1, rv); check("R9 dir read keeps", rv, 8'h83);
      wr(1'b1, 8'h07);
      rd(1'b0, rv);
      rd(1'b1, rv); check("R9 data read clears", rv, 8'h07);
      check("R9 irq released", {7'd0, irq_n}, 8'h01);

      // R6 falling edge ignored in rising mode
      ctl_in = 1'b0; idle(4);
      rd(1'b1, rv); check("R6 fall ignored", rv, 8'h07);

      // R7 falling mode
      wr(1'b1, 8'h05);
      ctl_in = 1'b1; idle(4);
      rd(1'b1, rv); check("R7 rise ignored", rv, 8'h05);
      ctl_in = 1'b0; idle(4);
      rd(1'b1, rv); check("R7 fall sets", rv, 8'h85);
      check("R7 irq asserted", {7'd0, irq_n}, 8'h00);
      rd(1'b0, rv);

      // R8 flag sets with enable off, request held off
      wr(1'b1, 8'h04);
      ctl_in = 1'b1; idle(4);
      ctl_in = 1'b0; idle(4);
      rd(1'b1, rv); check("R8 flag while disabled", rv, 8'h84);
      check("R8 irq held off", {7'd0, irq_n}, 8'h01);
      wr(1'b1, 8'h05);
      check("R8 irq on enable", {7'd0, irq_n}, 8'h00);

      // R11 bit 7 and bits 6:3
      wr(1'b1, 8'h7D);
      rd(1'b1, rv); check("R11 bit7 write keeps flag", rv, 8'h85);
      rd(1'b0, rv);
      wr(1'b1, 8'h85);
      rd(1'b1, rv); check("R11 bit7 write cannot set", rv, 8'h05);

      // R10 edge in the same clock as a clearing read
      wr(1'b1, 8'h07);
      ctl_in = 1'b1;
      idle(2);
      rd(1'b0, rv);
      rd(1'b1, rv); check("R10 edge beats clear", rv, 8'h87);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule